// File: doc/BRIEF.md
# Instruction Queue with Branch Folding

This block is a six-entry in-order instruction queue that sits between instruction fetch and dispatch. Each cycle fetch offers a bundle of up to four decoded instructions, each tagged as ordinary or branch. Branch tags say whether the branch writes the link or count register, whether it is predicted taken, and whether the target lookup hit the target cache. The queue accepts as much of the bundle as it can and reports that count back to fetch. Every cycle it offers up to two instructions at its two oldest positions.

Branches leave the stream early. A branch predicted taken that does not write the link or count register is folded as it arrives. It is counted as accepted but never stored, and the bundle slots behind it are refused, because they belong to the wrong path. A redirect pulse tells fetch to continue at the target. A not-taken branch is stored. When it reaches one of the two dispatch positions it is expelled, and that position carries no useful work for the cycle. A branch that writes the link or count register is never removed. It travels through the queue and leaves as a completion-slot request instead of an issue, so that its register write retires in program order. A full completion queue holds such an entry in place, together with every entry behind it.

A target-cache miss on a folded branch closes the fetch side for a fixed gap before target instructions are accepted. A flush empties the whole queue in one cycle.

Top module: `branch_fold_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty. No dispatch position is active, redirectValid is low, and with fetchCount at 0 fetchTake is 0.
- R2: The number of stored entries never exceeds six. An offered instruction that would be stored is accepted only while a free entry remains after this cycle's dispatch. Acceptance stops at the first refused slot. Bundle slot 0 is the oldest, the valid slots are 0 to fetchCount-1, and slot i sits at fetchWord[i*32 +: 32].
- R3: Dispatch consumes from position 0 (oldest) and then position 1, in order. Position 1 is consumed only if position 0 is consumed in the same cycle. An ordinary instruction leaves with issueValid high, and its word is on slotWord[k*32 +: 32] for position k.
- R4: A bundle slot with fetchBranch=1, fetchPredTaken=1 and fetchLinkUpd=0 is folded. It is counted in fetchTake without needing a free entry, it is never stored or dispatched, redirectValid is high in that cycle, and no later slot of the bundle is accepted.
- R5: On a fold, redirectHit copies that slot's fetchTgtHit. After a hit, fetch is accepted again in the next cycle. After a miss, fetchTake is 0 for exactly the next two cycles.
- R6: A stored branch with fetchPredTaken=0 and fetchLinkUpd=0 is expelled when it is at a dispatch position. slotExpel is high for that position, issueValid and complReq are low for it, and the position counts as used.
- R7: A branch with fetchLinkUpd=1 is stored like an ordinary instruction and leaves with complReq high and issueValid low. If it is predicted taken, redirectValid and redirectHit behave as in R4 and R5, and later bundle slots are refused.
- R8: While cqFull is high, an entry that needs a completion slot is not consumed, and no later position is consumed in that cycle.
- R9: While flush is high, no position is active, fetchTake is 0 and redirectValid is low. In the following cycle the queue is empty, and any pending miss gap is cancelled.
- R10: At most one of issueValid, complReq and slotExpel is high for any one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue this cycle |
| cqFull | input | 1 | Completion queue has no free slot |
| fetchCount | input | 3 | Number of valid bundle slots, from slot 0 |
| fetchWord | input | 128 | Bundle instruction words, slot i at bits i*32 +: 32 |
| fetchBranch | input | 4 | Slot holds a branch |
| fetchPredTaken | input | 4 | Branch predicted taken |
| fetchLinkUpd | input | 4 | Branch writes the link or count register |
| fetchTgtHit | input | 4 | Target-cache hit for a taken branch |
| fetchTake | output | 3 | Bundle slots accepted this cycle, folded ones included |
| redirectValid | output | 1 | A taken branch was seen; fetch continues at its target |
| redirectHit | output | 1 | The redirecting branch hit the target cache |
| issueValid | output | 2 | Position k sends an instruction to execution |
| complReq | output | 2 | Position k requests a completion-queue slot |
| slotExpel | output | 2 | Position k expels a not-taken branch |
| slotWord | output | 64 | Word at position k, bits k*32 +: 32 |

## Verification
A fold on the fetch side and an expel or a completion stall on the dispatch side can fall in the same cycle. The fold's acceptance limit depends on how many positions dispatch frees in that same cycle, so the two decisions interact. The bench provokes this by offering full bundles whose taken and not-taken branches are mixed at random, while it toggles cqFull and now and then asserts flush. A behavioural queue model predicts every position's action and word, the accepted count and the redirect flags, and each of these is compared on every clock.

// File: rtl/bfq_pkg.sv
package bfq_pkg;
  localparam int IQ_DEPTH = 6;
  localparam int DISP_W   = 2;
  localparam int FETCH_W  = 4;
  localparam int CNT_W    = $clog2(IQ_DEPTH + 1);
  localparam int TAKE_W   = $clog2(FETCH_W + 1);

  typedef enum logic [1:0] {
    KIND_OP   = 2'd0,
    KIND_SKIP = 2'd1,
    KIND_LINK = 2'd2
  } entryKind_t;

  typedef struct packed {
    logic             flush;
    logic [CNT_W-1:0] consume;
    logic [CNT_W-1:0] append;
  } strobes_t;
endpackage

// File: rtl/bfq_data.sv
module bfq_data
  import bfq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    strobes,
  input  logic [FETCH_W*WORD_W-1:0]   fetchWord,
  input  entryKind_t [FETCH_W-1:0]    fetchKind,
  output logic [CNT_W-1:0]            occ,
  output logic [DISP_W*WORD_W-1:0]    headWord,
  output entryKind_t [DISP_W-1:0]     headKind
);
  localparam int SHIFT_N = DISP_W + 1;

  logic [WORD_W-1:0] qWord [IQ_DEPTH];
  entryKind_t        qKind [IQ_DEPTH];
  logic [WORD_W-1:0] nWord [IQ_DEPTH];
  entryKind_t        nKind [IQ_DEPTH];
  logic [WORD_W-1:0] shWord [IQ_DEPTH][SHIFT_N];
  entryKind_t        shKind [IQ_DEPTH][SHIFT_N];
  int                keepCnt;

  assign keepCnt = int'(occ) - int'(strobes.consume);

  for (genvar g = 0; g < IQ_DEPTH; g++) begin : gEntry
    for (genvar s = 0; s < SHIFT_N; s++) begin : gShift
      if (g + s < IQ_DEPTH) begin : gIn
        assign shWord[g][s] = qWord[g+s];
        assign shKind[g][s] = qKind[g+s];
      end else begin : gOut
        assign shWord[g][s] = '0;
        assign shKind[g][s] = KIND_OP;
      end
    end

    always_comb begin
      nWord[g] = qWord[g];
      nKind[g] = qKind[g];
      if (g < keepCnt) begin
        for (int s = 0; s < SHIFT_N; s++) begin
          if (int'(strobes.consume) == s) begin
            nWord[g] = shWord[g][s];
            nKind[g] = shKind[g][s];
          end
        end
      end else begin
        for (int f = 0; f < FETCH_W; f++) begin
          if ((g - keepCnt) == f && f < int'(strobes.append)) begin
            nWord[g] = fetchWord[f*WORD_W +: WORD_W];
            nKind[g] = fetchKind[f];
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        qWord[g] <= '0;
        qKind[g] <= KIND_OP;
      end else begin
        qWord[g] <= nWord[g];
        qKind[g] <= nKind[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) occ <= '0;
    else occ <= occ - strobes.consume + strobes.append;
  end

  for (genvar k = 0; k < DISP_W; k++) begin : gHead
    assign headWord[k*WORD_W +: WORD_W] = qWord[k];
    assign headKind[k] = qKind[k];
  end
endmodule

// File: rtl/bfq_ctrl.sv
module bfq_ctrl
  import bfq_pkg::*;
#(
  parameter int MISS_GAP = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     cqFull,
  input  logic [CNT_W-1:0]         occ,
  input  entryKind_t [DISP_W-1:0]  headKind,
  input  logic [TAKE_W-1:0]        fetchCount,
  input  logic [FETCH_W-1:0]       fetchBranch,
  input  logic [FETCH_W-1:0]       fetchPredTaken,
  input  logic [FETCH_W-1:0]       fetchLinkUpd,
  input  logic [FETCH_W-1:0]       fetchTgtHit,
  output strobes_t                 strobes,
  output entryKind_t [FETCH_W-1:0] fetchKind,
  output logic [TAKE_W-1:0]        fetchTake,
  output logic                     redirectValid,
  output logic                     redirectHit,
  output logic [DISP_W-1:0]        issueValid,
  output logic [DISP_W-1:0]        complReq,
  output logic [DISP_W-1:0]        slotExpel
);
  localparam int GAP_W = $clog2(MISS_GAP + 2);

  logic [GAP_W-1:0]   gapCnt;
  logic [FETCH_W-1:0] isFold;
  int                 consumed;
  int                 accepted;
  int                 written;
  int                 freeCnt;
  logic               dispStop;
  logic               fetchClosed;

  // Decode each bundle slot into the kind it would be stored as.
  for (genvar i = 0; i < FETCH_W; i++) begin : gDecode
    assign isFold[i] = fetchBranch[i] & fetchPredTaken[i] & ~fetchLinkUpd[i];
    always_comb begin
      if (!fetchBranch[i])     fetchKind[i] = KIND_OP;
      else if (fetchLinkUpd[i]) fetchKind[i] = KIND_LINK;
      else                      fetchKind[i] = KIND_SKIP;
    end
  end

  // Dispatch side: in-order walk over the dispatch positions.
  always_comb begin
    consumed   = 0;
    dispStop   = 1'b0;
    issueValid = '0;
    complReq   = '0;
    slotExpel  = '0;
    if (!flush) begin
      for (int k = 0; k < DISP_W; k++) begin
        if (!dispStop) begin
          if (k >= int'(occ)) begin
            dispStop = 1'b1;
          end else if (headKind[k] == KIND_LINK && cqFull) begin
            dispStop = 1'b1;
          end else begin
            case (headKind[k])
              KIND_LINK: complReq[k]   = 1'b1;
              KIND_SKIP: slotExpel[k]  = 1'b1;
              default:   issueValid[k] = 1'b1;
            endcase
            consumed = consumed + 1;
          end
        end
      end
    end
  end

  // Fetch side: accept in order, fold taken branches, stop at a redirect.
  always_comb begin
    freeCnt       = IQ_DEPTH - (int'(occ) - consumed);
    accepted      = 0;
    written       = 0;
    fetchClosed   = 1'b0;
    redirectValid = 1'b0;
    redirectHit   = 1'b0;
    if (!flush && gapCnt == '0) begin
      for (int i = 0; i < FETCH_W; i++) begin
        if (!fetchClosed && i < int'(fetchCount)) begin
          if (isFold[i]) begin
            accepted      = accepted + 1;
            fetchClosed   = 1'b1;
            redirectValid = 1'b1;
            redirectHit   = fetchTgtHit[i];
          end else if (written < freeCnt) begin
            accepted = accepted + 1;
            written  = written + 1;
            if (fetchBranch[i] && fetchPredTaken[i]) begin
              fetchClosed   = 1'b1;
              redirectValid = 1'b1;
              redirectHit   = fetchTgtHit[i];
            end
          end else begin
            fetchClosed = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush)                gapCnt <= '0;
    else if (redirectValid && !redirectHit) gapCnt <= GAP_W'(MISS_GAP);
    else if (gapCnt != '0)             gapCnt <= gapCnt - 1'b1;
  end

  assign fetchTake       = TAKE_W'(accepted);
  assign strobes.flush   = flush;
  assign strobes.consume = CNT_W'(consumed);
  assign strobes.append  = CNT_W'(written);
endmodule

// File: rtl/branch_fold_queue.sv
module branch_fold_queue
  import bfq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int MISS_GAP = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      flush,
  input  logic                      cqFull,
  input  logic [TAKE_W-1:0]         fetchCount,
  input  logic [FETCH_W*WORD_W-1:0] fetchWord,
  input  logic [FETCH_W-1:0]        fetchBranch,
  input  logic [FETCH_W-1:0]        fetchPredTaken,
  input  logic [FETCH_W-1:0]        fetchLinkUpd,
  input  logic [FETCH_W-1:0]        fetchTgtHit,
  output logic [TAKE_W-1:0]         fetchTake,
  output logic                      redirectValid,
  output logic                      redirectHit,
  output logic [DISP_W-1:0]         issueValid,
  output logic [DISP_W-1:0]         complReq,
  output logic [DISP_W-1:0]         slotExpel,
  output logic [DISP_W*WORD_W-1:0]  slotWord
);
  strobes_t                 strobes;
  entryKind_t [FETCH_W-1:0] fetchKind;
  entryKind_t [DISP_W-1:0]  headKind;
  logic [CNT_W-1:0]         occ;

  bfq_ctrl #(.MISS_GAP(MISS_GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .cqFull(cqFull),
    .occ(occ), .headKind(headKind), .fetchCount(fetchCount),
    .fetchBranch(fetchBranch), .fetchPredTaken(fetchPredTaken),
    .fetchLinkUpd(fetchLinkUpd), .fetchTgtHit(fetchTgtHit),
    .strobes(strobes), .fetchKind(fetchKind), .fetchTake(fetchTake),
    .redirectValid(redirectValid), .redirectHit(redirectHit),
    .issueValid(issueValid), .complReq(complReq), .slotExpel(slotExpel)
  );

  bfq_data #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fetchWord(fetchWord), .fetchKind(fetchKind),
    .occ(occ), .headWord(slotWord), .headKind(headKind)
  );
endmodule

// File: rtl/bfq_checker.sv
module bfq_checker
  import bfq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              cqFull,
  input logic [TAKE_W-1:0] fetchCount,
  input logic [TAKE_W-1:0] fetchTake,
  input logic              redirectValid,
  input logic              redirectHit,
  input logic [DISP_W-1:0] issueValid,
  input logic [DISP_W-1:0] complReq,
  input logic [DISP_W-1:0] slotExpel
);
  logic [DISP_W-1:0] posActive;
  assign posActive = issueValid | complReq | slotExpel;

  assert_take_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchTake <= fetchCount) && (int'(fetchTake) <= FETCH_W));

  assert_dispatch_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    posActive[1] |-> posActive[0]);

  assert_fold_counted_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (fetchTake != '0));

  assert_miss_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !redirectHit && !flush) |=> (fetchTake == '0));

  assert_cq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    cqFull |-> (complReq == '0));

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (fetchTake == '0 && posActive == '0 && !redirectValid));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (posActive == '0));

  for (genvar k = 0; k < DISP_W; k++) begin : gExcl
    assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({issueValid[k], complReq[k], slotExpel[k]}));
  end
endmodule

bind branch_fold_queue bfq_checker uChk (
  .clk(clk), .rstN(rstN), .flush(flush), .cqFull(cqFull),
  .fetchCount(fetchCount), .fetchTake(fetchTake),
  .redirectValid(redirectValid), .redirectHit(redirectHit),
  .issueValid(issueValid), .complReq(complReq), .slotExpel(slotExpel)
);

// File: tb/branch_fold_queue_test.sv
module branch_fold_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W   = 32;
  localparam int FETCH_W  = 4;
  localparam int DISP_W   = 2;
  localparam int DEPTH    = 6;
  localparam int MISS_GAP = 2;
  localparam int PROG_N   = 6000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic cqFull = 1'b0;
  logic [2:0] fetchCount = '0;
  logic [FETCH_W*WORD_W-1:0] fetchWord = '0;
  logic [FETCH_W-1:0] fetchBranch = '0, fetchPredTaken = '0, fetchLinkUpd = '0, fetchTgtHit = '0;
  logic [2:0] fetchTake;
  logic redirectValid, redirectHit;
  logic [DISP_W-1:0] issueValid, complReq, slotExpel;
  logic [DISP_W*WORD_W-1:0] slotWord;

  branch_fold_queue uut (
    .clk(clk), .rstN(rstN), .flush(flush), .cqFull(cqFull),
    .fetchCount(fetchCount), .fetchWord(fetchWord), .fetchBranch(fetchBranch),
    .fetchPredTaken(fetchPredTaken), .fetchLinkUpd(fetchLinkUpd),
    .fetchTgtHit(fetchTgtHit), .fetchTake(fetchTake),
    .redirectValid(redirectValid), .redirectHit(redirectHit),
    .issueValid(issueValid), .complReq(complReq), .slotExpel(slotExpel),
    .slotWord(slotWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int pWord [PROG_N];
  bit pBr [PROG_N], pPred [PROG_N], pLink [PROG_N], pHit [PROG_N];
  int mqWord [$];
  int mqKind [$];   // 0 ordinary, 1 not-taken branch, 2 link/count branch
  int gap = 0;
  int ptr = 0;
  int unsigned rs = 32'h1234_5678;

  function automatic int rnd(input int m);
    rs = rs * 32'd1103515245 + 32'd12345;
    return int'((rs >> 16) % m);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic setProg(input int i, input bit br, input bit pr, input bit lk, input bit ht);
    pBr[i] = br; pPred[i] = pr; pLink[i] = lk; pHit[i] = ht;
  endtask

  task automatic buildProg();
    for (int i = 0; i < PROG_N; i++) begin
      int r;
      pWord[i] = 32'h1000 + i;
      r = rnd(100);
      if (r < 60)      setProg(i, 0, 0, 0, 0);
      else if (r < 70) setProg(i, 1, 0, 0, 0);
      else if (r < 80) setProg(i, 1, bit'(rnd(2)), 1, bit'(rnd(2)));
      else             setProg(i, 1, 1, 0, bit'(rnd(2)));
    end
    // Directed head: expel, link, fold hit, fold miss, taken link, back-to-back branches.
    for (int i = 0; i < 24; i++) setProg(i, 0, 0, 0, 0);
    setProg(3, 1, 0, 0, 0);
    setProg(6, 1, 0, 1, 0);
    setProg(8, 1, 1, 0, 1);
    setProg(10, 1, 1, 0, 0);
    setProg(12, 1, 1, 1, 1);
    setProg(15, 1, 0, 0, 0);
    setProg(16, 1, 0, 0, 0);
    setProg(18, 1, 1, 0, 1);
    setProg(19, 1, 1, 0, 0);
  endtask

  task automatic stepCycle(input bit fl, input bit cq, input int cnt);
    int n, eTake, written, cons, idx, act;
    bit stop, closed, eRed, eHit;
    int eAct [DISP_W];
    string sTag [DISP_W];
    string tTag;
    @(negedge clk);
    n = cnt;
    if (ptr + n > PROG_N) n = PROG_N - ptr;
    flush = fl; cqFull = cq; fetchCount = 3'(n);
    for (int i = 0; i < FETCH_W; i++) begin
      idx = ptr + i;
      if (idx < PROG_N) begin
        fetchWord[i*WORD_W +: WORD_W] = pWord[idx];
        fetchBranch[i] = pBr[idx]; fetchPredTaken[i] = pPred[idx];
        fetchLinkUpd[i] = pLink[idx]; fetchTgtHit[i] = pHit[idx];
      end else begin
        fetchWord[i*WORD_W +: WORD_W] = '0;
        fetchBranch[i] = 0; fetchPredTaken[i] = 0; fetchLinkUpd[i] = 0; fetchTgtHit[i] = 0;
      end
    end
    #1;
    cons = 0; stop = 0;
    for (int k = 0; k < DISP_W; k++) begin
      eAct[k] = 0;
      sTag[k] = fl ? "R9" : "R3";
    end
    if (!fl) begin
      for (int k = 0; k < DISP_W; k++) begin
        if (!stop) begin
          if (k >= mqKind.size()) stop = 1;
          else if (mqKind[k] == 2 && cq) begin stop = 1; sTag[k] = "R8"; end
          else begin
            if (mqKind[k] == 0) begin eAct[k] = 1; sTag[k] = "R3"; end
            else if (mqKind[k] == 2) begin eAct[k] = 2; sTag[k] = "R7"; end
            else begin eAct[k] = 3; sTag[k] = "R6"; end
            cons++;
          end
        end
      end
    end
    eTake = 0; written = 0; closed = 0; eRed = 0; eHit = 0;
    tTag = fl ? "R9" : "R2";
    if (!fl && gap > 0) begin
      tTag = "R5";
      gap--;
    end else if (!fl) begin
      for (int i = 0; i < n; i++) begin
        if (!closed) begin
          idx = ptr + i;
          if (pBr[idx] && pPred[idx] && !pLink[idx]) begin
            eTake++; closed = 1; eRed = 1; eHit = pHit[idx]; tTag = "R4";
          end else if (mqKind.size() - cons + written < DEPTH) begin
            eTake++; written++;
            if (pBr[idx] && pPred[idx]) begin
              closed = 1; eRed = 1; eHit = pHit[idx]; tTag = "R7";
            end
          end else closed = 1;
        end
      end
    end
    for (int k = 0; k < DISP_W; k++) begin
      act = 0;
      if ((32'(issueValid[k]) + 32'(complReq[k]) + 32'(slotExpel[k])) > 1) act = 9;
      else if (issueValid[k]) act = 1;
      else if (complReq[k]) act = 2;
      else if (slotExpel[k]) act = 3;
      check(act == eAct[k], (act == 9) ? "R10" : sTag[k], $sformatf("position %0d action", k), act, eAct[k]);
      if (eAct[k] != 0)
        check(slotWord[k*WORD_W +: WORD_W] == 32'(mqWord[k]), sTag[k],
              $sformatf("position %0d word", k), slotWord[k*WORD_W +: WORD_W], mqWord[k]);
    end
    check(int'(fetchTake) == eTake, tTag, "fetchTake", fetchTake, eTake);
    check(redirectValid == eRed, "R4", "redirectValid", redirectValid, eRed);
    if (eRed) check(redirectHit == eHit, "R5", "redirectHit", redirectHit, eHit);
    // Advance the reference queue.
    for (int c = 0; c < cons; c++) begin
      void'(mqWord.pop_front());
      void'(mqKind.pop_front());
    end
    for (int w = 0; w < written; w++) begin
      idx = ptr + w;
      mqWord.push_back(pWord[idx]);
      mqKind.push_back(!pBr[idx] ? 0 : (pLink[idx] ? 2 : 1));
    end
    if (eRed && !eHit) gap = MISS_GAP;
    if (fl) begin
      mqWord.delete(); mqKind.delete(); gap = 0;
    end
    ptr += eTake;
  endtask

  initial begin
    buildProg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: empty and idle right after reset.
    check((issueValid | complReq | slotExpel) == '0, "R1", "positions after reset",
          issueValid | complReq | slotExpel, 0);
    check(redirectValid == 1'b0, "R1", "redirect after reset", redirectValid, 0);
    check(fetchTake == '0, "R1", "fetchTake after reset", fetchTake, 0);
    // Directed head with full bundles, no stalls.
    for (int c = 0; c < 30; c++) stepCycle(0, 0, 4);
    // Completion queue full: link entries hold, queue fills to capacity.
    for (int c = 0; c < 10; c++) stepCycle(0, 1, 4);
    // Flush during a busy stream, then refill.
    stepCycle(1, 0, 4);
    for (int c = 0; c < 6; c++) stepCycle(0, 0, 4);
    // Random mix of bundle sizes, stalls and flushes.
    for (int c = 0; c < 2500; c++) stepCycle(rnd(80) == 0, rnd(10) < 3, rnd(5));
    // Drain.
    for (int c = 0; c < 20; c++) stepCycle(0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ptr, PROG_N);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule